// File: doc/BRIEF.md
# Byte Lane Alignment Unit

This block sits between a processor core and a data memory whose port is one word wide. The core hands it an access kind, a byte address computed by the ALU, the register value to be stored, and the word that memory returned. The block produces the word-aligned address for memory, a per-byte write enable, a write word with the store byte placed in its lane, and the value to write back to the register file. The memory array is outside the block.

Byte loads take any lane of the returned word, chosen by the low address bits, and extend it with zeros or with its sign. Byte stores replicate the byte into every lane and enable only the addressed lane, so a single byte is changed in place and no read of the old word is needed. The store data reaches the memory port on its own path, independent of the ALU that forms the address. Word accesses with nonzero low address bits are flagged and their write is blocked.

The logic is purely combinational. With the default 32-bit word, kind codes are: 0 word load, 1 byte load with zero extension, 2 byte load with sign extension, 3 word store, 4 byte store, and any other code means no access.

Top module: `lsa_unit`

## Requirements
- R1: `mem_addr` equals `addr` with its two low bits forced to zero, for every kind code.
- R2: A word load (kind 0) with `addr[1:0]`=0 returns `mem_rdata` unchanged on `ld_value`.
- R3: A zero-extending byte load (kind 1) returns the byte of `mem_rdata` selected little-endian by `addr[1:0]` (0 picks bits 7:0, 3 picks bits 31:24) in `ld_value[7:0]`, with bits 31:8 zero.
- R4: A sign-extending byte load (kind 2) returns the same selected byte in bits 7:0 with bits 31:8 all equal to the byte's bit 7.
- R5: A word store (kind 3) with `addr[1:0]`=0 drives `mem_be`=4'b1111 and `mem_wdata`=`st_data`.
- R6: A byte store (kind 4) drives `mem_wdata` as `st_data[7:0]` copied into all four lanes and sets only bit `addr[1:0]` of `mem_be`.
- R7: A word load or word store with `addr[1:0]`≠0 sets `misalign`, drives `mem_be`=0, and returns `ld_value`=0.
- R8: Loads and undefined kind codes (5, 6, 7) drive `mem_be`=0; undefined codes also give `ld_value`=0 and `misalign`=0.
- R9: Byte accesses (kinds 1, 2, 4) never set `misalign`, at any value of `addr[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 3 | Access kind code |
| addr | input | 32 | Byte address from the ALU |
| st_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Word-aligned address to memory |
| mem_be | output | 4 | Per-byte write enable |
| mem_wdata | output | 32 | Lane-placed write word |
| ld_value | output | 32 | Extended load result for the register file |
| misalign | output | 1 | Word access at a non-word-aligned address |

## Verification
Byte loads are tried at all four lane offsets with a read word whose bytes are all distinct, so a wrong lane choice or a swapped byte order shows up at once, and with lane bytes whose top bit is set and clear, which separates zero from sign extension. Byte stores are driven at every offset with a store value whose upper bytes differ from its low byte, which exposes a wrong enable bit or a lane fed from the wrong byte. Word accesses are tried at every nonzero offset to show the flag and the blocked write, and the undefined codes are applied with high address bits set to confirm that nothing is enabled while the address still passes through aligned.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
   localparam logic [2:0] KIND_LW   = 3'd0;
   localparam logic [2:0] KIND_LBU  = 3'd1;
   localparam logic [2:0] KIND_LB   = 3'd2;
   localparam logic [2:0] KIND_SW   = 3'd3;
   localparam logic [2:0] KIND_SB   = 3'd4;
   localparam logic [2:0] KIND_NONE = 3'd7;

   function automatic logic kind_is_word(input logic [2:0] k);
      return (k == KIND_LW) || (k == KIND_SW);
   endfunction

   function automatic logic kind_is_load(input logic [2:0] k);
      return (k == KIND_LW) || (k == KIND_LBU) || (k == KIND_LB);
   endfunction

   function automatic logic kind_is_byte(input logic [2:0] k);
      return (k == KIND_LBU) || (k == KIND_LB) || (k == KIND_SB);
   endfunction
endpackage

// File: rtl/lsa_lane_dec.sv
module lsa_lane_dec
   import lsa_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int BYTES          = 4,
   parameter bit BIG_LANE_ORDER = 1'b0,
   localparam int LANE_W        = $clog2(BYTES)
) (
   input  logic [2:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] word_addr,
   output logic [LANE_W-1:0] lane,
   output logic [BYTES-1:0]  lane_oh,
   output logic              misalign
);
   logic [LANE_W-1:0] offs;

   assign offs      = addr[LANE_W-1:0];
   assign word_addr = {addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
   assign misalign  = kind_is_word(kind) && (offs != '0);

   generate
      if (BIG_LANE_ORDER) begin : g_big
         assign lane = ~offs;
      end else begin : g_little
         assign lane = offs;
      end
   endgenerate

   for (genvar g = 0; g < BYTES; g++) begin : g_oh
      assign lane_oh[g] = (lane == LANE_W'(g));
   end

   always_comb begin
      // R6
      dec_onehot_chk: assert ($onehot(lane_oh));
   end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
) (
   input  logic [2:0]        kind,
   input  logic [DATA_W-1:0] st_data,
   input  logic [BYTES-1:0]  lane_oh,
   input  logic              misalign,
   output logic [BYTES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);
   always_comb begin
      be    = '0;
      wdata = '0;
      case (kind)
         KIND_SW: begin
            wdata = st_data;
            if (!misalign) be = '1;
         end
         KIND_SB: begin
            wdata = {BYTES{st_data[7:0]}};
            be    = lane_oh;
         end
         default: begin
            be    = '0;
            wdata = '0;
         end
      endcase
   end

   always_comb begin
      if (kind == KIND_SB) begin
         // R6
         sb_one_lane_chk: assert ($countones(be) == 1);
      end
   end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
   import lsa_pkg::*;
#(
   parameter int DATA_W  = 32,
   localparam int BYTES  = DATA_W / 8,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic [2:0]        kind,
   input  logic [DATA_W-1:0] rdata,
   input  logic [LANE_W-1:0] lane,
   input  logic              misalign,
   output logic [DATA_W-1:0] ld_value
);
   logic [7:0] lanes [BYTES];
   logic [7:0] sel;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lanes[g] = rdata[8*g +: 8];
   end

   assign sel = lanes[lane];

   always_comb begin
      case (kind)
         KIND_LW:  ld_value = misalign ? '0 : rdata;
         KIND_LBU: ld_value = {{(DATA_W-8){1'b0}}, sel};
         KIND_LB:  ld_value = {{(DATA_W-8){sel[7]}}, sel};
         default:  ld_value = '0;
      endcase
   end

   always_comb begin
      if (kind == KIND_LBU || kind == KIND_LB) begin
         // R3
         ld_byte_chk: assert (ld_value[7:0] == 8'(rdata >> {lane, 3'b000}));
      end
   end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
   import lsa_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter bit BIG_LANE_ORDER = 1'b0,
   localparam int BYTES         = DATA_W / 8,
   localparam int LANE_W        = $clog2(BYTES)
) (
   input  logic [2:0]        acc_kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] ld_value,
   output logic              misalign
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 16)
         $error("lsa_unit: DATA_W must be a multiple of 8 and at least 16");
      if ((1 << LANE_W) != BYTES)
         $error("lsa_unit: byte count per word must be a power of two");
      if (ADDR_W <= LANE_W)
         $error("lsa_unit: ADDR_W too small for the lane field");
   endgenerate

   logic [LANE_W-1:0] lane;
   logic [BYTES-1:0]  lane_oh;

   lsa_lane_dec #(
      .ADDR_W         (ADDR_W),
      .BYTES          (BYTES),
      .BIG_LANE_ORDER (BIG_LANE_ORDER)
   ) u_dec (
      .kind      (acc_kind),
      .addr      (addr),
      .word_addr (mem_addr),
      .lane      (lane),
      .lane_oh   (lane_oh),
      .misalign  (misalign)
   );

   lsa_store_path #(.DATA_W(DATA_W)) u_st (
      .kind     (acc_kind),
      .st_data  (st_data),
      .lane_oh  (lane_oh),
      .misalign (misalign),
      .be       (mem_be),
      .wdata    (mem_wdata)
   );

   lsa_load_path #(.DATA_W(DATA_W)) u_ld (
      .kind     (acc_kind),
      .rdata    (mem_rdata),
      .lane     (lane),
      .misalign (misalign),
      .ld_value (ld_value)
   );

   always_comb begin
      // R7
      misalign_no_write_chk: assert (!misalign || mem_be == '0);
      // R8
      load_no_write_chk: assert (!kind_is_load(acc_kind) || mem_be == '0);
      // R9
      byte_never_flag_chk: assert (!kind_is_byte(acc_kind) || !misalign);
      if (acc_kind == KIND_SW && !misalign) begin
         // R5
         sw_full_word_chk: assert (mem_be == '1 && mem_wdata == st_data);
      end
   end
endmodule

// File: tb/lsa_unit_tb.sv
module lsa_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  acc_kind = 3'd7;
   logic [31:0] addr = '0;
   logic [31:0] st_data = '0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] ld_value;
   logic        misalign;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsa_unit u_dut (
      .acc_kind  (acc_kind),
      .addr      (addr),
      .st_data   (st_data),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_be    (mem_be),
      .mem_wdata (mem_wdata),
      .ld_value  (ld_value),
      .misalign  (misalign)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] k, input logic [31:0] a,
                        input logic [31:0] sd, input logic [31:0] rd);
      @(negedge clk);
      acc_kind  = k;
      addr      = a;
      st_data   = sd;
      mem_rdata = rd;
      #1;
   endtask

   function automatic logic [7:0] pick(input logic [31:0] w, input int ln);
      return w[8*ln +: 8];
   endfunction

   task automatic t_idle();
      drive(3'd7, 32'h0, 32'h0, 32'h0);
      chk("R8 idle be", {28'h0, mem_be}, 32'h0);
      chk("R8 idle ld", ld_value, 32'h0);
      chk("R8 idle misalign", {31'h0, misalign}, 32'h0);
   endtask

   task automatic t_addr();
      for (int k = 0; k < 8; k++) begin
         drive(3'(k), 32'hDEAD_BEE0 | 32'(k % 4), 32'h1, 32'h2);
         chk("R1 aligned address", mem_addr, 32'hDEAD_BEE0);
      end
   endtask

   task automatic t_lw();
      drive(3'd0, 32'h0000_1000, 32'h0, 32'hCAFE_F00D);
      chk("R2 word load", ld_value, 32'hCAFE_F00D);
      chk("R8 word load be", {28'h0, mem_be}, 32'h0);
      chk("R2 word load flag", {31'h0, misalign}, 32'h0);
   endtask

   task automatic t_lbu();
      logic [31:0] w = 32'h8A_F1_7E_05;
      for (int l = 0; l < 4; l++) begin
         drive(3'd1, 32'h0000_2000 + 32'(l), 32'h0, w);
         chk("R3 byte load zero ext", ld_value, {24'h0, pick(w, l)});
         chk("R9 byte load no flag", {31'h0, misalign}, 32'h0);
      end
   endtask

   task automatic t_lb();
      logic [31:0] w = 32'h8A_F1_7E_05;
      for (int l = 0; l < 4; l++) begin
         drive(3'd2, 32'h0000_3000 + 32'(l), 32'h0, w);
         chk("R4 byte load sign ext", ld_value,
             {{24{pick(w, l)[7]}}, pick(w, l)});
         chk("R8 byte load be", {28'h0, mem_be}, 32'h0);
      end
   endtask

   task automatic t_sw();
      drive(3'd3, 32'h0000_4000, 32'h1234_5678, 32'hFFFF_FFFF);
      chk("R5 word store be", {28'h0, mem_be}, 32'hF);
      chk("R5 word store data", mem_wdata, 32'h1234_5678);
   endtask

   task automatic t_sb();
      for (int l = 0; l < 4; l++) begin
         drive(3'd4, 32'h0000_5000 + 32'(l), 32'hAABB_CC3C, 32'h0);
         chk("R6 byte store be", {28'h0, mem_be}, 32'(1 << l));
         chk("R6 byte store data", mem_wdata, 32'h3C3C_3C3C);
         chk("R9 byte store no flag", {31'h0, misalign}, 32'h0);
      end
   endtask

   task automatic t_misalign();
      for (int l = 1; l < 4; l++) begin
         drive(3'd3, 32'h0000_6000 + 32'(l), 32'h1111_2222, 32'h0);
         chk("R7 word store flag", {31'h0, misalign}, 32'h1);
         chk("R7 word store be", {28'h0, mem_be}, 32'h0);
         drive(3'd0, 32'h0000_6000 + 32'(l), 32'h0, 32'h5566_7788);
         chk("R7 word load flag", {31'h0, misalign}, 32'h1);
         chk("R7 word load value", ld_value, 32'h0);
      end
   endtask

   task automatic t_undefined();
      for (int k = 5; k < 8; k++) begin
         drive(3'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
         chk("R8 undefined be", {28'h0, mem_be}, 32'h0);
         chk("R8 undefined ld", ld_value, 32'h0);
         chk("R8 undefined flag", {31'h0, misalign}, 32'h0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_idle();
      rst_n = 1'b1;
      t_addr();
      t_lw();
      t_lbu();
      t_lb();
      t_sw();
      t_sb();
      t_misalign();
      t_undefined();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule